// File: doc/BRIEF.md
# Drive Attention Status Logic

This block holds the attention state for a group of disk drives that share one controller bus. Each drive keeps an attention status bit and an internal error flag. An abnormal condition, or a change in drive status, raises the bit. A set of controller actions clears it. The attention requests of all drives are ORed into a single shared line, the way a wire-OR bus line behaves. A controller can therefore see attention from any drive, and the line stays high until every drive has let go.

Several controller actions clear the status bit, and each follows its own rules:

- A bus-wide initialize clears both the bit and the error flag on every drive. It is blocked while the power-fail input is high.
- A drive-clear command clears both the bit and the error flag on the addressed drive only.
- A write to the attention-summary register clears the bit of each drive whose mask bit is one. The error flag is left latched.
- A command write with GO set clears the bit only when all three of these hold:
  - the write had no control parity error;
  - the function code is legal;
  - the drive had no error latched beforehand.

When an error or status event arrives in the same cycle as a clearing action, the event wins.

Top module: `attn_bank`

## Requirements
- R1: After a synchronous reset, `ata`, `attn_req` and `attn_line` are all zero.
- R2: In the cycle after an `err_ev` or `stat_ev` pulse on a drive, that drive's `ata` bit is 1. A drive's `attn_req` bit is 1 whenever its `ata` bit or its error flag is set, and an `err_ev` pulse sets the error flag.
- R3: `attn_line` is 1 exactly when any drive's `attn_req` is 1. Clearing one drive leaves the line high while another drive still requests.
- R4: `bus_init` with `pwr_fail` low clears `ata` and the error flag of every drive in the next cycle.
- R5: While `pwr_fail` is 1, `bus_init` has no effect.
- R6: A command write with `cmd_go`=1 and `cmd_dclr`=1, free of parity error and illegal code, is a drive clear. It clears `ata` and the error flag of the drive numbered `cmd_unit` only.
- R7: An `as_wr` cycle clears `ata` of each drive whose bit in `as_bits` is 1, with bit i belonging to drive i. The error flag is kept, so `attn_req` stays 1 for a drive with an error.
- R8: A command write with `cmd_go`=1, no parity error, a legal code and no latched error clears `ata` of the addressed drive only.
- R9: A command write to a drive with `cmd_par`=1 does not clear its `ata` and sets its error flag.
- R10: A command write with GO to a drive whose error flag is already set does not clear its `ata`.
- R11: A command write with GO and `cmd_ill`=1 sets the error flag and `ata` of the addressed drive.
- R12: An error or status event in the same cycle as any clearing action leaves `ata` set. An error event there also leaves the error flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_fail | input | 1 | Power-fail indication; blocks `bus_init` |
| bus_init | input | 1 | Bus-wide initialize pulse |
| err_ev | input | NUM_DRIVES | Per-drive abnormal-condition pulse |
| stat_ev | input | NUM_DRIVES | Per-drive status-change pulse |
| as_wr | input | 1 | Attention-summary register write strobe |
| as_bits | input | NUM_DRIVES | Attention-summary write data, bit i for drive i |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_unit | input | UNIT_W | Drive number addressed by the write |
| cmd_go | input | 1 | GO bit of the written command |
| cmd_dclr | input | 1 | Function code is drive clear |
| cmd_par | input | 1 | Control parity error on this write |
| cmd_ill | input | 1 | Function code is illegal |
| ata | output | NUM_DRIVES | Per-drive attention status bit |
| attn_req | output | NUM_DRIVES | Per-drive attention request (status or error) |
| attn_line | output | 1 | Shared ORed attention line |

## Verification
The bench targets the exception paths of command writes: parity errors, an error latched before the write, and illegal codes. A design that ignored any of these would drop `ata` and lose an attention the controller never saw. It also pairs clearing actions with events in the same cycle, where a wrong priority would silently discard a new error. Other tests check that an attention-summary write keeps the error visible on `attn_req`, that `pwr_fail` blocks initialize, and that clearing one of two requesting drives does not release the shared line.

// File: rtl/attn_pkg.sv
package attn_pkg;
  // Decoded fields of one command register write.
  typedef struct packed {
    logic go;
    logic dclr;
    logic par;
    logic ill;
  } cmd_t;
endpackage

// File: rtl/attn_decode.sv
module attn_decode #(
  parameter int NUM_DRIVES = 8,
  parameter int UNIT_W     = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr,
  input  logic [UNIT_W-1:0]     unit,
  output logic [NUM_DRIVES-1:0] sel
);
  for (genvar i = 0; i < NUM_DRIVES; i++) begin : g_sel
    assign sel[i] = wr && (unit == UNIT_W'(i));
  end

  // At most one drive is addressed by a command write (R6, R8).
  assert_one_sel_R8: assert property (@(posedge clk) disable iff (rst) $onehot0(sel));
endmodule

// File: rtl/attn_cell.sv
module attn_cell
  import attn_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic err_ev,
  input  logic stat_ev,
  input  logic init_clr,
  input  logic as_clr,
  input  logic sel,
  input  cmd_t cmd,
  output logic ata,
  output logic req
);
  logic ata_q, err_q;
  logic go_cmd, dclr_cmd, go_ok, err_set, clr_err, clr_ata;

  assign go_cmd   = sel && cmd.go;
  assign dclr_cmd = go_cmd && cmd.dclr && !cmd.par && !cmd.ill;
  assign go_ok    = go_cmd && !cmd.par && !cmd.ill && !err_q;
  assign err_set  = err_ev || (sel && cmd.par) || (go_cmd && cmd.ill);
  assign clr_err  = init_clr || dclr_cmd;
  assign clr_ata  = clr_err || as_clr || go_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      ata_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      err_q <= err_set || (err_q && !clr_err);
      ata_q <= err_set || stat_ev || (ata_q && !clr_ata);
    end
  end

  assign ata = ata_q;
  assign req = ata_q || err_q;

  assert_set_wins_R12: assert property (@(posedge clk) disable iff (rst)
    (err_set || stat_ev) |=> ata_q);
  assert_err_kept_R12: assert property (@(posedge clk) disable iff (rst)
    err_set |=> err_q);
  assert_init_clears_R4: assert property (@(posedge clk) disable iff (rst)
    (init_clr && !err_set && !stat_ev) |=> (!ata_q && !err_q));
  assert_as_keeps_err_R7: assert property (@(posedge clk) disable iff (rst)
    (as_clr && err_q && !init_clr && !dclr_cmd) |=> err_q);
  assert_prior_err_R10: assert property (@(posedge clk) disable iff (rst)
    (go_cmd && err_q && ata_q && !as_clr && !init_clr && !dclr_cmd) |=> ata_q);
endmodule

// File: rtl/attn_bank.sv
module attn_bank
  import attn_pkg::*;
#(
  parameter  int NUM_DRIVES = 8,
  localparam int UNIT_W     = (NUM_DRIVES > 1) ? $clog2(NUM_DRIVES) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  pwr_fail,
  input  logic                  bus_init,
  input  logic [NUM_DRIVES-1:0] err_ev,
  input  logic [NUM_DRIVES-1:0] stat_ev,
  input  logic                  as_wr,
  input  logic [NUM_DRIVES-1:0] as_bits,
  input  logic                  cmd_wr,
  input  logic [UNIT_W-1:0]     cmd_unit,
  input  logic                  cmd_go,
  input  logic                  cmd_dclr,
  input  logic                  cmd_par,
  input  logic                  cmd_ill,
  output logic [NUM_DRIVES-1:0] ata,
  output logic [NUM_DRIVES-1:0] attn_req,
  output logic                  attn_line
);
  logic [NUM_DRIVES-1:0] sel;
  logic                  init_ok;
  cmd_t                  cmd;

  assign init_ok = bus_init && !pwr_fail;
  assign cmd     = '{go: cmd_go, dclr: cmd_dclr, par: cmd_par, ill: cmd_ill};

  attn_decode #(.NUM_DRIVES(NUM_DRIVES), .UNIT_W(UNIT_W)) u_dec (
    .clk(clk), .rst(rst), .wr(cmd_wr), .unit(cmd_unit), .sel(sel)
  );

  for (genvar i = 0; i < NUM_DRIVES; i++) begin : g_drv
    attn_cell u_cell (
      .clk(clk), .rst(rst),
      .err_ev(err_ev[i]), .stat_ev(stat_ev[i]),
      .init_clr(init_ok), .as_clr(as_wr && as_bits[i]),
      .sel(sel[i]), .cmd(cmd),
      .ata(ata[i]), .req(attn_req[i])
    );
  end

  // Shared line: any drive requesting holds it high.
  assign attn_line = |attn_req;

  assert_pfail_blocks_R5: assert property (@(posedge clk) disable iff (rst)
    (pwr_fail && bus_init && !as_wr && !cmd_wr && (err_ev == '0) && (stat_ev == '0))
      |=> (attn_req == $past(attn_req)));
endmodule

// File: tb/attn_bank_tb.sv
module attn_bank_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;

  logic clk = 1'b0, rst;
  logic pwr_fail, bus_init, as_wr, cmd_wr, cmd_go, cmd_dclr, cmd_par, cmd_ill;
  logic [N-1:0] err_ev, stat_ev, as_bits, ata, attn_req;
  logic [2:0] cmd_unit;
  logic attn_line;
  int tests = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  attn_bank #(.NUM_DRIVES(N)) u_dut (
    .clk(clk), .rst(rst), .pwr_fail(pwr_fail), .bus_init(bus_init),
    .err_ev(err_ev), .stat_ev(stat_ev), .as_wr(as_wr), .as_bits(as_bits),
    .cmd_wr(cmd_wr), .cmd_unit(cmd_unit), .cmd_go(cmd_go), .cmd_dclr(cmd_dclr),
    .cmd_par(cmd_par), .cmd_ill(cmd_ill),
    .ata(ata), .attn_req(attn_req), .attn_line(attn_line)
  );

  task automatic idle();
    pwr_fail = 0; bus_init = 0; err_ev = '0; stat_ev = '0; as_wr = 0; as_bits = '0;
    cmd_wr = 0; cmd_unit = '0; cmd_go = 0; cmd_dclr = 0; cmd_par = 0; cmd_ill = 0;
  endtask

  // Apply the currently driven inputs for one clock edge, then return to idle.
  task automatic step();
    @(negedge clk);
    idle();
  endtask

  task automatic chk(string req, logic [N-1:0] act, logic [N-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic cmd(int unit, bit go, bit dclr, bit par, bit ill);
    cmd_wr = 1; cmd_unit = 3'(unit); cmd_go = go; cmd_dclr = dclr; cmd_par = par; cmd_ill = ill;
    step();
  endtask

  task automatic as_clear(logic [N-1:0] m);
    as_wr = 1; as_bits = m; step();
  endtask

  task automatic do_init();
    bus_init = 1; step();
  endtask

  task automatic t_reset();
    chk("R1 ata", ata, '0);
    chk("R1 req", attn_req, '0);
    chk("R1 line", {7'b0, attn_line}, 8'h00);
  endtask

  task automatic t_set_and_as();
    err_ev = 8'h04; step();
    chk("R2 err sets ata", ata, 8'h04);
    chk("R2 line", {7'b0, attn_line}, 8'h01);
    stat_ev = 8'h20; step();
    chk("R2 stat sets ata", ata, 8'h24);
    as_clear(8'h24);
    chk("R7 as clears ata", ata, 8'h00);
    chk("R7 error kept", attn_req, 8'h04);
    do_init();
    chk("R4 init clears", attn_req, 8'h00);
  endtask

  task automatic t_shared();
    stat_ev = 8'h42; step();
    as_clear(8'h02);
    chk("R3 line held", {7'b0, attn_line}, 8'h01);
    as_clear(8'h40);
    chk("R3 line released", {7'b0, attn_line}, 8'h00);
  endtask

  task automatic t_pfail();
    err_ev = 8'h08; step();
    pwr_fail = 1; bus_init = 1; step();
    chk("R5 init ignored", attn_req, 8'h08);
    do_init();
    chk("R4 init after pfail", attn_req, 8'h00);
  endtask

  task automatic t_go();
    stat_ev = 8'h11; step();
    cmd(4, 1, 0, 0, 0);
    chk("R8 go clears unit4 only", ata, 8'h01);
    cmd(0, 0, 0, 0, 0);
    chk("R8 no go no clear", ata, 8'h01);
    do_init();
  endtask

  task automatic t_parity();
    stat_ev = 8'h84; step();
    cmd(7, 1, 0, 1, 0);
    chk("R9 parity keeps ata", ata, 8'h84);
    as_clear(8'h80);
    chk("R9 parity set error", attn_req, 8'h84);
    cmd(7, 1, 1, 0, 0);
    chk("R6 drive clear unit7 only", attn_req, 8'h04);
    do_init();
  endtask

  task automatic t_prior_err();
    err_ev = 8'h02; step();
    as_clear(8'h02);
    stat_ev = 8'h02; step();
    cmd(1, 1, 0, 0, 0);
    chk("R10 prior error keeps ata", ata, 8'h02);
    cmd(1, 1, 1, 0, 0);
    chk("R6 drive clear error", attn_req, 8'h00);
  endtask

  task automatic t_illegal();
    cmd(3, 1, 0, 0, 1);
    chk("R11 illegal sets ata", ata, 8'h08);
    as_clear(8'h08);
    chk("R11 illegal sets error", attn_req, 8'h08);
    do_init();
  endtask

  task automatic t_priority();
    err_ev = 8'h20; as_wr = 1; as_bits = 8'hFF; step();
    chk("R12 err beats as clear", ata, 8'h20);
    err_ev = 8'h40; bus_init = 1; step();
    chk("R12 err beats init", ata, 8'h40);
    as_clear(8'h40);
    chk("R12 err flag survives init", attn_req, 8'h40);
    stat_ev = 8'h10; cmd_wr = 1; cmd_unit = 3'd4; cmd_go = 1; step();
    chk("R12 stat beats go", ata, 8'h10);
    do_init();
  endtask

  initial begin
    idle();
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_set_and_as();
    t_shared();
    t_pfail();
    t_go();
    t_parity();
    t_prior_err();
    t_illegal();
    t_priority();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule